// File: doc/BRIEF.md
# TDM Buffer Descriptor Queue Channel

This block manages buffer hand-off for one direction of a framed TDM stream. Software submits buffer descriptors through a small register port. Each descriptor is a 7-bit index that names a multiframe-aligned buffer slot, and it goes into a submission queue. A datapath engine takes descriptors from that queue in order. It spends a programmable number of cycles filling or draining each buffer, then places a completion word into a completion queue. Software reads the completion word back through the same descriptor port. In this block the datapath is a stub: it waits the programmed interval and tags each completion with the two CRC results present on its `crc_ok` input when the completion is pushed.

The register port has two addresses. Address 0 is control/status. A write sets the enable bit (0) and the mode field (bits 2:1), and a 1 in bit 12 clears the sticky starvation flag. A read returns the enabled state, the alignment indication, the empty/full state of both queues and the sticky flag. Address 1 is the descriptor port. A write submits a descriptor, and a read returns the oldest completion and pops it.

The engine is a four-state machine:
- IDLE: the channel is disabled.
- FETCH: the engine needs a buffer.
- BUSY: the engine counts the interval.
- DONE: the engine holds a completion until the completion queue has room.

The transitions are:
- IDLE→FETCH when enabled.
- FETCH→IDLE when disabled.
- FETCH→BUSY when it pops a descriptor.
- BUSY→DONE when the interval expires.
- DONE→FETCH, or DONE→IDLE if disabled, once the completion has been pushed.

A parameter selects the receive or the transmit variant.

Top module: `bdq_channel`

## Requirements
- R1: After reset, a status read returns 0x0500 (bit 8 input-queue empty, bit 10 output-queue empty, every other bit 0), and a descriptor-port read returns 0x0000.
- R2: A control write stores bit 0 as the enable, which status bit 0 reflects, and bits 2:1 as the mode, which appears on `cfg_mode`. The mode codes are 0 none/transparent, 1 byte/TS0, 2 basic frame/TS0+CRC4 and 3 multiframe/TS0+CRC4+E-bits.
- R3: The input queue holds 4 descriptors. Status bit 9 is set when it is full and bit 8 when it is empty. A descriptor write to a full input queue is dropped.
- R4: Only descriptor write bits 6:0 form the buffer address, and the upper bits are ignored.
- R5: Descriptors complete in submission order. Each completion word has bit 15 set, bits 14:13 equal to `crc_ok[1:0]` at the push, bits 6:0 equal to the address, and all other bits 0.
- R6: While the engine waits in FETCH, a descriptor written at clock edge E appears in the output queue at edge E+period+2.
- R7: Status bit 12 is sticky. It sets in any cycle in which the enabled engine needs a buffer and the input queue is empty. It clears only on a control write with bit 12 set, and it never sets while the channel is disabled.
- R8: When a clear write and a starvation event fall in the same cycle, the flag stays set.
- R9: The output queue holds 4 completions. Status bit 11 is set when it is full and bit 10 when it is empty. A full output queue stalls the engine in DONE without loss. A descriptor read pops only a valid entry, and a read of an empty queue returns a word with bit 15 clear and changes nothing.
- R10: In the receive variant, status bit 1 equals `aligned_in`. In the transmit variant, bit 1 reads 0.
- R11: While disabled, the engine consumes no descriptor, and submitted descriptors stay queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the descriptor port) |
| reg_sel | input | 1 | 0 selects control/status, 1 selects the descriptor port |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid in the cycle of the access |
| period | input | PER_W | Cycles the stub spends per buffer (0 acts as 1) |
| aligned_in | input | 1 | Alignment indication from the framer (receive variant) |
| crc_ok | input | 2 | Per-submultiframe CRC results captured into completions |
| cfg_mode | output | 2 | Stored mode field for the datapath |

## Verification
Two collisions are provoked deliberately. The first is a flag-clear write while the enabled engine starves in FETCH. Set-over-clear priority means status bit 12 must still read 1 afterwards, and a later clear issued while disabled must leave it 0. The second is a completion read racing a completion push: the completion queue is filled while the engine holds a finished buffer in DONE, and it is then drained. Every address must come back exactly once and in submission order.

// File: rtl/bdq_pkg.sv
package bdq_pkg;
    localparam int WORD_W    = 16;
    localparam int BIT_EN    = 0;
    localparam int BIT_ALIGN = 1;
    localparam int BIT_IN_E  = 8;
    localparam int BIT_IN_F  = 9;
    localparam int BIT_OUT_E = 10;
    localparam int BIT_OUT_F = 11;
    localparam int BIT_FLAG  = 12;
    localparam int BIT_CRC_L = 13;
    localparam int BIT_VALID = 15;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_FETCH = 2'd1,
        ENG_BUSY  = 2'd2,
        ENG_DONE  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/bdq_fifo.sv
module bdq_fifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           din,
    input  logic                       pop,
    output logic [WIDTH-1:0]           dout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end
endmodule

// File: rtl/bdq_engine.sv
module bdq_engine
    import bdq_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [PER_W-1:0]  period,
    input  logic              in_empty,
    input  logic [ADDR_W-1:0] in_head,
    output logic              in_pop,
    input  logic              out_full,
    input  logic [1:0]        crc_ok,
    output logic              out_push,
    output logic [WORD_W-1:0] out_word,
    output logic              starve
);
    eng_state_e        state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [PER_W-1:0]  cnt_q;
    logic              last;

    assign last = ({1'b0, cnt_q} + 1'b1) >= {1'b0, period};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ENG_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ENG_IDLE:  if (enable) state_nx = ENG_FETCH;
            ENG_FETCH: if (!enable) state_nx = ENG_IDLE;
                       else if (!in_empty) state_nx = ENG_BUSY;
            ENG_BUSY:  if (last) state_nx = ENG_DONE;
            ENG_DONE:  if (!out_full) state_nx = enable ? ENG_FETCH : ENG_IDLE;
            default:   state_nx = ENG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_pop   = 1'b0;
        starve   = 1'b0;
        out_push = 1'b0;
        out_word = '0;
        out_word[BIT_VALID]              = 1'b1;
        out_word[BIT_CRC_L+1:BIT_CRC_L] = crc_ok;
        out_word[ADDR_W-1:0]            = addr_q;
        unique case (state)
            ENG_FETCH: begin
                in_pop = enable && !in_empty;
                starve = enable && in_empty;
            end
            ENG_DONE: out_push = !out_full;
            default: ;
        endcase
    end

    // buffer address and interval counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else if (in_pop) begin
            addr_q <= in_head;
            cnt_q  <= '0;
        end else if (state == ENG_BUSY && !last) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/bdq_channel.sv
module bdq_channel
    import bdq_pkg::*;
#(
    parameter bit IS_TX  = 1'b0,
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 7,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [PER_W-1:0]  period,
    input  logic              aligned_in,
    input  logic [1:0]        crc_ok,
    output logic [1:0]        cfg_mode
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              enable_q, flag_q;
    logic [1:0]        mode_q;
    logic              csr_wr, desc_wr, desc_rd, clr_req;
    logic              in_pop, in_empty, in_full;
    logic [ADDR_W-1:0] in_head;
    logic [CNT_W-1:0]  in_count, out_count;
    logic              out_push, out_pop, out_empty, out_full;
    logic [WORD_W-1:0] out_word, out_head, status;
    logic              starve, align_bit;

    assign csr_wr  = reg_wr && !reg_sel;
    assign desc_wr = reg_wr && reg_sel;
    assign desc_rd = reg_rd && reg_sel;
    assign clr_req = csr_wr && reg_wdata[BIT_FLAG];
    assign out_pop = desc_rd && !out_empty;
    assign cfg_mode = mode_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            mode_q   <= 2'd0;
            flag_q   <= 1'b0;
        end else begin
            if (csr_wr) begin
                enable_q <= reg_wdata[BIT_EN];
                mode_q   <= reg_wdata[2:1];
            end
            if (starve)       flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    generate
        if (IS_TX) begin : g_tx
            assign align_bit = 1'b0;
        end else begin : g_rx
            assign align_bit = aligned_in;
        end
    endgenerate

    bdq_fifo #(.WIDTH(ADDR_W), .DEPTH(DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n),
        .push(desc_wr), .din(reg_wdata[ADDR_W-1:0]),
        .pop(in_pop), .dout(in_head),
        .count(in_count), .empty(in_empty), .full(in_full)
    );

    bdq_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n),
        .push(out_push), .din(out_word),
        .pop(out_pop), .dout(out_head),
        .count(out_count), .empty(out_empty), .full(out_full)
    );

    bdq_engine #(.ADDR_W(ADDR_W), .PER_W(PER_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .enable(enable_q), .period(period),
        .in_empty(in_empty), .in_head(in_head), .in_pop(in_pop),
        .out_full(out_full), .crc_ok(crc_ok),
        .out_push(out_push), .out_word(out_word), .starve(starve)
    );

    always_comb begin
        status            = '0;
        status[BIT_EN]    = enable_q;
        status[BIT_ALIGN] = align_bit;
        status[BIT_IN_E]  = in_empty;
        status[BIT_IN_F]  = in_full;
        status[BIT_OUT_E] = out_empty;
        status[BIT_OUT_F] = out_full;
        status[BIT_FLAG]  = flag_q;
    end

    assign reg_rdata = reg_sel ? (out_empty ? '0 : out_head) : status;
endmodule

// File: rtl/bdq_checker.sv
module bdq_checker #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flag_q,
    input logic             starve,
    input logic             clr_req,
    input logic             desc_wr,
    input logic             in_pop,
    input logic [CNT_W-1:0] in_count,
    input logic             desc_rd,
    input logic             out_push,
    input logic [15:0]      out_word,
    input logic [CNT_W-1:0] out_count
);
    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_count == CNT_W'(DEPTH) && desc_wr && !in_pop) |=> (in_count == CNT_W'(DEPTH)));

    assert_completion_tagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> out_word[15]);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);

    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (starve && clr_req) |=> flag_q);

    assert_no_pop_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_rd && out_count == '0 && !out_push) |=> (out_count == '0));

    assert_push_has_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_push |-> (out_count < CNT_W'(DEPTH)));
endmodule

bind bdq_channel bdq_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_bdq_checker (
    .clk(clk), .rst_n(rst_n), .flag_q(flag_q), .starve(starve), .clr_req(clr_req),
    .desc_wr(desc_wr), .in_pop(in_pop), .in_count(in_count), .desc_rd(desc_rd),
    .out_push(out_push), .out_word(out_word), .out_count(out_count)
);

// File: tb/test_bdq_channel.sv
`timescale 1ns/1ps
module test_bdq_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  period = 8'd3;
    logic        aligned_in = 1'b0;
    logic [1:0]  crc_ok = 2'b11;
    logic [1:0]  cfg_mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bdq_channel i_bdq_channel (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .period(period),
        .aligned_in(aligned_in), .crc_ok(crc_ok), .cfg_mode(cfg_mode)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] st(input bit en, input bit al, input bit ie, input bit inf,
                                       input bit oe, input bit of, input bit fl);
        return 16'(en) | (16'(al) << 1) | (16'(ie) << 8) | (16'(inf) << 9) |
               (16'(oe) << 10) | (16'(of) << 11) | (16'(fl) << 12);
    endfunction

    task automatic wr(input bit sel, input logic [15:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_status(output logic [15:0] v);
        reg_sel = 1'b0;
        #1 v = reg_rdata;
    endtask

    task automatic rd_desc(output logic [15:0] v);
        @(negedge clk);
        reg_sel = 1'b1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_status(v);  check("R1 status", v, 16'h0500);
        rd_desc(v);    check("R1 desc read", v, 16'h0000);

        // R2 mode sweep (disabled), R10 alignment reflection
        for (int m = 0; m < 4; m++) begin
            wr(1'b0, 16'(m << 1));
            rd_status(v);
            check("R2 mode", {14'd0, cfg_mode}, 16'(m));
            check("R2 disabled", v & 16'h0001, 16'h0000);
        end
        for (int a = 0; a < 2; a++) begin
            aligned_in = a[0];
            rd_status(v);
            check("R10 align bit", (v >> 1) & 16'h1, 16'(a));
        end
        aligned_in = 1'b0;

        // R3/R11 fill input while disabled, fifth write dropped
        for (int i = 0; i < 5; i++) begin
            wr(1'b1, 16'hFF80 | 16'(7'h10 + i));
            rd_status(v);
            check("R3 in-full bit", (v >> 9) & 16'h1, (i >= 3) ? 16'h1 : 16'h0);
        end
        repeat (20) @(negedge clk);
        rd_status(v); check("R11 held while disabled", v, st(0,0,0,1,1,0,0));

        // R5/R7/R9 enable, period 3, drain all four
        crc_ok = 2'b10;
        wr(1'b0, 16'h0007);
        rd_status(v); check("R2 enabled bit", v & 16'h1, 16'h1);
        check("R2 mode 3", {14'd0, cfg_mode}, 16'd3);
        repeat (40) @(negedge clk);
        rd_status(v); check("R9 out full R7 flag", v, st(1,0,1,0,0,1,1));
        for (int i = 0; i < 4; i++) begin
            rd_desc(v);
            check("R4 R5 completion", v, 16'h8000 | (16'(2'b10) << 13) | 16'(7'h10 + i));
        end
        rd_desc(v); check("R3 fifth dropped", v, 16'h0000);

        // R9 stall in DONE and ordered drain
        crc_ok = 2'b01;
        for (int i = 0; i < 4; i++) wr(1'b1, 16'h5500 | 16'(7'h40 + i));
        repeat (40) @(negedge clk);
        for (int i = 4; i < 8; i++) wr(1'b1, 16'h5500 | 16'(7'h40 + i));
        repeat (40) @(negedge clk);
        rd_status(v); check("R9 stall status", v, st(1,0,0,0,0,1,1));
        for (int i = 0; i < 4; i++) begin
            rd_desc(v);
            check("R9 order first", v, 16'h8000 | (16'(2'b01) << 13) | 16'(7'h40 + i));
        end
        repeat (40) @(negedge clk);
        for (int i = 4; i < 8; i++) begin
            rd_desc(v);
            check("R9 order second", v, 16'h8000 | (16'(2'b01) << 13) | 16'(7'h40 + i));
        end

        // R8 clear colliding with starvation
        wr(1'b0, 16'h1007);
        rd_status(v); check("R8 flag kept", v, st(1,0,1,0,1,0,1));
        // R7 disable, then clear
        wr(1'b0, 16'h0006);
        wr(1'b0, 16'h1006);
        rd_status(v); check("R7 cleared", v, st(0,0,1,0,1,0,0));
        repeat (10) @(negedge clk);
        rd_status(v); check("R7 no set while disabled", v, st(0,0,1,0,1,0,0));

        // R6 latency with period 5
        period = 8'd5;
        crc_ok = 2'b11;
        wr(1'b0, 16'h0007);
        repeat (4) @(negedge clk);
        wr(1'b1, 16'h0011);
        repeat (5 + 1) @(negedge clk);
        rd_status(v); check("R6 not yet", (v >> 10) & 16'h1, 16'h1);
        @(negedge clk);
        rd_status(v); check("R6 arrived", (v >> 10) & 16'h1, 16'h0);
        rd_desc(v); check("R6 R5 word", v, 16'hE011);

        // R9 read on empty changes nothing
        rd_status(v);
        rd_desc(v2); check("R9 empty read", v2, 16'h0000);
        rd_status(v2); check("R9 status unchanged", v2, v);

        finish_run();
    end
endmodule